// File: doc/BRIEF.md
# Sentinel Tag Guard for Load-Load Ordering

This block is the tag side of a direct-mapped first-level data cache. It keeps total-store-order load-load ordering without a load queue. Each line carries a sentinel flag and a reorder-buffer (ROB) index. A load that issues while an older load has not yet sent its cache request sets the flag on the line it hits and records its own ROB index. While the flag is set, the line refuses to be evicted. A remote invalidation of the line also gets no acknowledgement, so a remote store cannot complete while the speculation is still exposed.

The flag clears when the load named in the line's ROB-index field commits. A withheld acknowledgement then goes out on a separate release channel and the line is dropped. Once a flagged line has seen an invalidation or an eviction request, it freezes: its ROB-index field takes no further updates, and any out-of-order load to that line is told to reissue in program order. This prevents a local load loop from starving a remote writer. A load whose set is held by a different flagged line is served without allocation.

All addresses on the ports are line addresses. The low index bits select the set and the remaining upper bits form the tag.

Top module: `llo_sentinel_tags`

## Requirements
- R1: After reset no line is valid or flagged. Every response output (load response, acknowledge, retry, eviction result, release) is low.
- R2: Every load request gets a response on `ld_rsp_valid` exactly one cycle later, with `ld_rsp` coded as follows: 0 = tag hit; 1 = miss that allocated the line; 2 = served without allocation; 3 = must be reissued in program order.
- R3: An out-of-order load (`ld_ooo`=1) that hits an unflagged line, or that allocates a line, flags that line with its ROB index. An in-order load never flags a line.
- R4: An out-of-order load that hits a flagged, unfrozen line replaces the ROB-index field only if it is younger. Age uses the top ROB bit as a wrap bit: with equal wrap bits the larger low part is younger; with different wrap bits the smaller low part is younger.
- R5: An invalidation that misses, or that hits an unflagged line, drops the line if present and raises `inv_ack` one cycle later. An invalidation that hits a flagged line raises neither `inv_ack` nor `inv_retry`, and the line holds the acknowledgement.
- R6: A second invalidation to a line that already holds an acknowledgement raises `inv_retry` one cycle later and leaves the held acknowledgement in place.
- R7: An eviction request to a flagged line answers `ev_deny` one cycle later and keeps the line. Any other eviction answers `ev_ok` and drops the line.
- R8: After a flagged line receives an invalidation or an eviction request, an out-of-order load hitting it gets code 3 and its ROB index is not recorded. An in-order load still hits.
- R9: A load that misses in a set held by a different flagged line gets code 2, and the flagged line stays in place.
- R10: A commit whose ROB index equals a flagged line's field clears the flag and the frozen state. If that line holds an acknowledgement, the line is dropped and `rel_ack` pulses for one cycle, one cycle after the commit, with `rel_addr` giving the line address. A commit with any other index changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Load request strobe |
| ld_addr | input | LA_W | Load line address |
| ld_rob | input | ROB_W | ROB index of the load, top bit is the wrap bit |
| ld_ooo | input | 1 | An older load has not yet sent its cache request |
| ld_rsp_valid | output | 1 | Load response strobe |
| ld_rsp | output | 2 | Load response code |
| inv_valid | input | 1 | Remote invalidation request |
| inv_addr | input | LA_W | Invalidation line address |
| inv_ack | output | 1 | Immediate acknowledgement |
| inv_retry | output | 1 | Request refused, resend later |
| ev_valid | input | 1 | Local eviction request |
| ev_set | input | IDX_W | Set to evict |
| ev_ok | output | 1 | Eviction done |
| ev_deny | output | 1 | Eviction refused |
| cm_valid | input | 1 | A load commits |
| cm_rob | input | ROB_W | ROB index of the committing load |
| rel_ack | output | 1 | Released acknowledgement |
| rel_addr | output | LA_W | Line address of the released acknowledgement |

## Verification
Load responses, immediate acknowledgements and retries, and eviction results all come from one register stage, so each is due in the cycle after its request. A released acknowledgement comes from a per-line flag set at the commit edge, so it is also due in the cycle after the commit. The bench applies each request at a falling edge, keeps it through one rising edge, and reads the results at the next falling edge. It also reads an idle cycle after a release, to confirm that the release pulse lasts only one cycle.

// File: rtl/llo_pkg.sv
package llo_pkg;

    typedef enum logic [1:0] {
        LD_HIT     = 2'd0,
        LD_FILL    = 2'd1,
        LD_NOCACHE = 2'd2,
        LD_INORDER = 2'd3
    } ld_res_e;

    typedef enum logic [1:0] {
        INV_NONE  = 2'd0,
        INV_ACK   = 2'd1,
        INV_HOLD  = 2'd2,
        INV_RETRY = 2'd3
    } inv_res_e;

    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_OK   = 2'd1,
        EV_DENY = 2'd2
    } ev_res_e;

    // True when index a is younger than index b; bit w-1 is the wrap bit.
    function automatic logic rob_younger(input logic [31:0] a,
                                         input logic [31:0] b,
                                         input int unsigned w);
        logic [31:0] m;
        m = (32'd1 << (w - 1)) - 32'd1;
        if (a[w-1] != b[w-1]) return (a & m) < (b & m);
        return (a & m) > (b & m);
    endfunction

endpackage

// File: rtl/llo_line.sv
module llo_line
    import llo_pkg::*;
#(
    parameter int TAG_W = 9,
    parameter int ROB_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cm_valid,
    input  logic [ROB_W-1:0] cm_rob,
    input  logic             inv_sel,
    input  logic [TAG_W-1:0] inv_tag,
    input  logic             ev_sel,
    input  logic             ld_sel,
    input  logic [TAG_W-1:0] ld_tag,
    input  logic [ROB_W-1:0] ld_rob,
    input  logic             ld_ooo,
    input  logic             rel_take,
    output logic             rel_req,
    output logic [TAG_W-1:0] rel_tag,
    output inv_res_e         inv_res,
    output ev_res_e          ev_res,
    output ld_res_e          ld_res
);

    typedef struct packed {
        logic             valid;
        logic [TAG_W-1:0] tag;
        logic             mark;
        logic [ROB_W-1:0] rob;
        logic             frozen;
        logic             pend;
        logic             rel;
        logic [TAG_W-1:0] rtag;
    } line_t;

    line_t q, d;

    always_comb begin
        d       = q;
        inv_res = INV_NONE;
        ev_res  = EV_NONE;
        ld_res  = LD_HIT;

        if (rel_take) d.rel = 1'b0;

        // commit of the named load lifts the sentinel
        if (cm_valid && q.mark && q.rob == cm_rob) begin
            d.mark   = 1'b0;
            d.frozen = 1'b0;
            if (q.pend) begin
                d.pend  = 1'b0;
                d.rel   = 1'b1;
                d.rtag  = q.tag;
                d.valid = 1'b0;
            end
        end

        // remote invalidation
        if (inv_sel) begin
            if (!(d.valid && d.tag == inv_tag)) begin
                inv_res = INV_ACK;
            end else if (!d.mark) begin
                d.valid = 1'b0;
                inv_res = INV_ACK;
            end else if (d.pend) begin
                inv_res = INV_RETRY;
            end else begin
                d.pend   = 1'b1;
                d.frozen = 1'b1;
                inv_res  = INV_HOLD;
            end
        end

        // local eviction
        if (ev_sel) begin
            if (d.valid && d.mark) begin
                d.frozen = 1'b1;
                ev_res   = EV_DENY;
            end else begin
                d.valid = 1'b0;
                ev_res  = EV_OK;
            end
        end

        // load lookup
        if (ld_sel) begin
            if (d.valid && d.tag == ld_tag) begin
                if (ld_ooo) begin
                    if (d.frozen) begin
                        ld_res = LD_INORDER;
                    end else if (!d.mark) begin
                        d.mark = 1'b1;
                        d.rob  = ld_rob;
                    end else if (rob_younger(32'(ld_rob), 32'(d.rob), ROB_W)) begin
                        d.rob = ld_rob;
                    end
                end
            end else if (d.valid && d.mark) begin
                ld_res = LD_NOCACHE;
            end else begin
                d.valid  = 1'b1;
                d.tag    = ld_tag;
                d.mark   = ld_ooo;
                d.rob    = ld_rob;
                d.frozen = 1'b0;
                d.pend   = 1'b0;
                ld_res   = LD_FILL;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign rel_req = q.rel;
    assign rel_tag = q.rtag;

endmodule

// File: rtl/llo_rel_pick.sv
module llo_rel_pick #(
    parameter int N     = 8,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic [N-1:0]     gnt,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    // lowest set index wins
    always_comb begin
        gnt = '0;
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt    = '0;
                gnt[i] = 1'b1;
                any    = 1'b1;
                idx    = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/llo_sentinel_tags.sv
module llo_sentinel_tags
    import llo_pkg::*;
#(
    parameter int NLINES = 8,
    parameter int LA_W   = 12,
    parameter int ROB_W  = 6,
    localparam int IDX_W = (NLINES > 1) ? $clog2(NLINES) : 1,
    localparam int TAG_W = LA_W - IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_valid,
    input  logic [LA_W-1:0]  ld_addr,
    input  logic [ROB_W-1:0] ld_rob,
    input  logic             ld_ooo,
    output logic             ld_rsp_valid,
    output logic [1:0]       ld_rsp,
    input  logic             inv_valid,
    input  logic [LA_W-1:0]  inv_addr,
    output logic             inv_ack,
    output logic             inv_retry,
    input  logic             ev_valid,
    input  logic [IDX_W-1:0] ev_set,
    output logic             ev_ok,
    output logic             ev_deny,
    input  logic             cm_valid,
    input  logic [ROB_W-1:0] cm_rob,
    output logic             rel_ack,
    output logic [LA_W-1:0]  rel_addr
);

    logic [IDX_W-1:0] ld_idx, inv_idx, pick_idx;
    logic [TAG_W-1:0] ld_tag, inv_tag;
    logic [NLINES-1:0] rel_req, rel_gnt;
    logic [TAG_W-1:0] rel_tag_a [NLINES];
    inv_res_e         inv_res_a [NLINES];
    ev_res_e          ev_res_a  [NLINES];
    ld_res_e          ld_res_a  [NLINES];

    assign ld_idx  = ld_addr[IDX_W-1:0];
    assign ld_tag  = ld_addr[LA_W-1:IDX_W];
    assign inv_idx = inv_addr[IDX_W-1:0];
    assign inv_tag = inv_addr[LA_W-1:IDX_W];

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        llo_line #(.TAG_W(TAG_W), .ROB_W(ROB_W)) u_line (
            .clk      (clk),
            .rst      (rst),
            .cm_valid (cm_valid),
            .cm_rob   (cm_rob),
            .inv_sel  (inv_valid && inv_idx == IDX_W'(g)),
            .inv_tag  (inv_tag),
            .ev_sel   (ev_valid && ev_set == IDX_W'(g)),
            .ld_sel   (ld_valid && ld_idx == IDX_W'(g)),
            .ld_tag   (ld_tag),
            .ld_rob   (ld_rob),
            .ld_ooo   (ld_ooo),
            .rel_take (rel_gnt[g]),
            .rel_req  (rel_req[g]),
            .rel_tag  (rel_tag_a[g]),
            .inv_res  (inv_res_a[g]),
            .ev_res   (ev_res_a[g]),
            .ld_res   (ld_res_a[g])
        );
    end

    llo_rel_pick #(.N(NLINES), .IDX_W(IDX_W)) u_pick (
        .req (rel_req),
        .gnt (rel_gnt),
        .any (rel_ack),
        .idx (pick_idx)
    );

    assign rel_addr = {rel_tag_a[pick_idx], pick_idx};

    always_ff @(posedge clk) begin
        if (rst) begin
            ld_rsp_valid <= 1'b0;
            ld_rsp       <= 2'd0;
            inv_ack      <= 1'b0;
            inv_retry    <= 1'b0;
            ev_ok        <= 1'b0;
            ev_deny      <= 1'b0;
        end else begin
            ld_rsp_valid <= ld_valid;
            ld_rsp       <= ld_valid ? ld_res_a[ld_idx] : 2'd0;
            inv_ack      <= inv_valid && inv_res_a[inv_idx] == INV_ACK;
            inv_retry    <= inv_valid && inv_res_a[inv_idx] == INV_RETRY;
            ev_ok        <= ev_valid && ev_res_a[ev_set] == EV_OK;
            ev_deny      <= ev_valid && ev_res_a[ev_set] == EV_DENY;
        end
    end

endmodule

// File: rtl/llo_sentinel_tags_chk.sv
module llo_sentinel_tags_chk (
    input logic clk,
    input logic rst,
    input logic ld_valid,
    input logic ld_rsp_valid,
    input logic inv_valid,
    input logic inv_ack,
    input logic inv_retry,
    input logic ev_valid,
    input logic ev_ok,
    input logic ev_deny,
    input logic cm_valid,
    input logic rel_ack
);

    AST_LDRSP_CAUSE: assert property (@(posedge clk) disable iff (rst)
        ld_rsp_valid |-> $past(ld_valid)); // R2

    AST_INV_CAUSE: assert property (@(posedge clk) disable iff (rst)
        (inv_ack || inv_retry) |-> $past(inv_valid)); // R5

    AST_INV_ONE_ANSWER: assert property (@(posedge clk) disable iff (rst)
        !(inv_ack && inv_retry)); // R6

    AST_EV_ANSWERED: assert property (@(posedge clk) disable iff (rst)
        ev_valid |=> (ev_ok || ev_deny)); // R7

    AST_EV_ONE_ANSWER: assert property (@(posedge clk) disable iff (rst)
        !(ev_ok && ev_deny)); // R7

    AST_REL_CAUSE: assert property (@(posedge clk) disable iff (rst)
        rel_ack |-> ($past(cm_valid) || $past(rel_ack))); // R10

endmodule

bind llo_sentinel_tags llo_sentinel_tags_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .ld_valid     (ld_valid),
    .ld_rsp_valid (ld_rsp_valid),
    .inv_valid    (inv_valid),
    .inv_ack      (inv_ack),
    .inv_retry    (inv_retry),
    .ev_valid     (ev_valid),
    .ev_ok        (ev_ok),
    .ev_deny      (ev_deny),
    .cm_valid     (cm_valid),
    .rel_ack      (rel_ack)
);

// File: tb/sim_llo_sentinel_tags.sv
module sim_llo_sentinel_tags;

    localparam int CLK_PERIOD = 10;
    localparam int LA_W  = 12;
    localparam int ROB_W = 6;
    localparam int IDX_W = 3;

    localparam logic [1:0] OP_LD = 2'd0, OP_INV = 2'd1, OP_EV = 2'd2, OP_CM = 2'd3;

    typedef struct packed {
        logic [1:0]       op;
        logic [LA_W-1:0]  addr;
        logic [ROB_W-1:0] rob;
        logic             ooo;
        logic [1:0]       exp;
        logic [3:0]       req;
    } vec_t;

    // line addresses: A=001 and B=009 share set 1, C=002, D=003, E=004
    localparam int NV = 28;
    localparam vec_t VEC [NV] = '{
        '{OP_LD,  12'h001, 6'd3,  1'b0, 2'd1, 4'd2},  // R2 fill
        '{OP_LD,  12'h001, 6'd3,  1'b0, 2'd0, 4'd2},  // R2 hit
        '{OP_LD,  12'h001, 6'd5,  1'b1, 2'd0, 4'd3},  // R3 flag with 5
        '{OP_LD,  12'h001, 6'd7,  1'b1, 2'd0, 4'd4},  // R4 younger 7 replaces
        '{OP_LD,  12'h009, 6'd8,  1'b0, 2'd2, 4'd9},  // R9 no allocation
        '{OP_EV,  12'h001, 6'd0,  1'b0, 2'd1, 4'd7},  // R7 deny, A kept (R9)
        '{OP_LD,  12'h001, 6'd9,  1'b1, 2'd3, 4'd8},  // R8 in order
        '{OP_LD,  12'h001, 6'd9,  1'b0, 2'd0, 4'd8},  // R8 in-order hit
        '{OP_CM,  12'h000, 6'd5,  1'b0, 2'd0, 4'd10}, // R10 stale index, no effect
        '{OP_INV, 12'h001, 6'd0,  1'b0, 2'd1, 4'd5},  // R5 held
        '{OP_INV, 12'h001, 6'd0,  1'b0, 2'd2, 4'd6},  // R6 retry
        '{OP_CM,  12'h001, 6'd7,  1'b0, 2'd1, 4'd10}, // R10 release A
        '{OP_LD,  12'h001, 6'd10, 1'b0, 2'd1, 4'd10}, // R10 line dropped
        '{OP_INV, 12'h001, 6'd0,  1'b0, 2'd0, 4'd3},  // R3 in-order fill not flagged
        '{OP_INV, 12'h002, 6'd0,  1'b0, 2'd0, 4'd5},  // R5 absent line
        '{OP_EV,  12'h002, 6'd0,  1'b0, 2'd0, 4'd7},  // R7 ok
        '{OP_LD,  12'h002, 6'd2,  1'b1, 2'd1, 4'd3},  // R3 ooo fill flags with 2
        '{OP_LD,  12'h002, 6'd1,  1'b1, 2'd0, 4'd4},  // R4 older 1 ignored
        '{OP_CM,  12'h000, 6'd1,  1'b0, 2'd0, 4'd4},  // R4 commit 1 no release
        '{OP_INV, 12'h002, 6'd0,  1'b0, 2'd1, 4'd4},  // R4 still flagged: held
        '{OP_CM,  12'h002, 6'd2,  1'b0, 2'd1, 4'd10}, // R10 release C
        '{OP_LD,  12'h003, 6'h1E, 1'b1, 2'd1, 4'd4},  // R4 wrap 0, low 30
        '{OP_LD,  12'h003, 6'h21, 1'b1, 2'd0, 4'd4},  // R4 wrap 1, low 1 is younger
        '{OP_CM,  12'h000, 6'h1E, 1'b0, 2'd0, 4'd4},  // R4 old index no longer named
        '{OP_EV,  12'h003, 6'd0,  1'b0, 2'd1, 4'd4},  // R4 still flagged: deny
        '{OP_CM,  12'h000, 6'h21, 1'b0, 2'd0, 4'd10}, // R10 clear, nothing held
        '{OP_EV,  12'h003, 6'd0,  1'b0, 2'd0, 4'd10}, // R10 flag gone: ok
        '{OP_LD,  12'h003, 6'd0,  1'b0, 2'd1, 4'd7}   // R7 evicted line refills
    };

    logic             clk = 1'b0;
    logic             rst;
    logic             ld_valid, ld_ooo, ld_rsp_valid;
    logic [LA_W-1:0]  ld_addr, inv_addr, rel_addr;
    logic [ROB_W-1:0] ld_rob, cm_rob;
    logic [1:0]       ld_rsp;
    logic             inv_valid, inv_ack, inv_retry;
    logic             ev_valid, ev_ok, ev_deny;
    logic [IDX_W-1:0] ev_set;
    logic             cm_valid, rel_ack;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    llo_sentinel_tags #(.NLINES(8), .LA_W(LA_W), .ROB_W(ROB_W)) u0 (
        .clk(clk), .rst(rst),
        .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_rob(ld_rob), .ld_ooo(ld_ooo),
        .ld_rsp_valid(ld_rsp_valid), .ld_rsp(ld_rsp),
        .inv_valid(inv_valid), .inv_addr(inv_addr), .inv_ack(inv_ack), .inv_retry(inv_retry),
        .ev_valid(ev_valid), .ev_set(ev_set), .ev_ok(ev_ok), .ev_deny(ev_deny),
        .cm_valid(cm_valid), .cm_rob(cm_rob), .rel_ack(rel_ack), .rel_addr(rel_addr)
    );

    task automatic check(input logic ok, input int req, input logic [15:0] act,
                         input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL R%0d: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        ld_valid = 1'b0; ld_addr = '0; ld_rob = '0; ld_ooo = 1'b0;
        inv_valid = 1'b0; inv_addr = '0;
        ev_valid = 1'b0; ev_set = '0;
        cm_valid = 1'b0; cm_rob = '0;
    endtask

    // called at a falling edge; inputs held over one rising edge, results read at the next falling edge
    task automatic run_op(input vec_t v);
        idle_inputs();
        case (v.op)
            OP_LD:  begin ld_valid = 1'b1; ld_addr = v.addr; ld_rob = v.rob; ld_ooo = v.ooo; end
            OP_INV: begin inv_valid = 1'b1; inv_addr = v.addr; end
            OP_EV:  begin ev_valid = 1'b1; ev_set = v.addr[IDX_W-1:0]; end
            default: begin cm_valid = 1'b1; cm_rob = v.rob; end
        endcase
        @(negedge clk);
        case (v.op)
            OP_LD: check(ld_rsp_valid && ld_rsp == v.exp, int'(v.req),
                         {13'd0, ld_rsp_valid, ld_rsp}, {14'd1, v.exp});
            OP_INV: check({inv_retry, inv_ack} == ((v.exp == 2'd0) ? 2'b01 :
                          (v.exp == 2'd2) ? 2'b10 : 2'b00), int'(v.req),
                          {14'd0, inv_retry, inv_ack}, {14'd0, v.exp});
            OP_EV: check({ev_deny, ev_ok} == ((v.exp == 2'd1) ? 2'b10 : 2'b01), int'(v.req),
                         {14'd0, ev_deny, ev_ok}, {14'd0, v.exp});
            default: check(rel_ack == v.exp[0] && (!v.exp[0] || rel_addr == v.addr), int'(v.req),
                           {3'd0, rel_ack, rel_addr}, {3'd0, v.exp[0], v.addr});
        endcase
        idle_inputs();
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual running expected done");
        finish_run();
    end

    initial begin
        idle_inputs();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check({ld_rsp_valid, inv_ack, inv_retry, ev_ok, ev_deny, rel_ack} == 6'b0, 1,
              {10'd0, ld_rsp_valid, inv_ack, inv_retry, ev_ok, ev_deny, rel_ack}, 16'd0);

        for (int i = 0; i < NV; i++) run_op(VEC[i]);

        // R2 no response without a request
        @(negedge clk);
        check(!ld_rsp_valid, 2, {15'd0, ld_rsp_valid}, 16'd0);

        // R10 release pulse lasts one cycle
        run_op('{OP_LD,  12'h004, 6'd12, 1'b1, 2'd1, 4'd3});
        run_op('{OP_INV, 12'h004, 6'd0,  1'b0, 2'd1, 4'd5});
        run_op('{OP_CM,  12'h004, 6'd12, 1'b0, 2'd1, 4'd10});
        @(negedge clk);
        check(!rel_ack, 10, {15'd0, rel_ack}, 16'd0);

        // R1 reset discards flags and lines
        run_op('{OP_LD, 12'h005, 6'd14, 1'b1, 2'd1, 4'd3});
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        run_op('{OP_INV, 12'h005, 6'd0, 1'b0, 2'd0, 4'd1});
        run_op('{OP_EV,  12'h005, 6'd0, 1'b0, 2'd0, 4'd1});

        finish_run();
    end

endmodule